// File: doc/BRIEF.md
# I2C Memory Target Protocol Engine

This block is the bus-facing half of a serial memory that answers as a target on a two-wire I2C bus. It oversamples SCL and SDA with a fast system clock and finds START and STOP conditions in the synchronised samples. It moves bytes in and out most significant bit first and pulls SDA low through a drive-enable output for acknowledge and for zero data bits.

After a START, the first byte picks the target. Two type codes are accepted, one for the main array and one for an auxiliary page. A three-bit chip-enable field must also match the strap inputs. A write selection is followed by two address bytes that load an internal address counter. The data bytes that follow are handed to a downstream write controller as single-cycle strobes, each with its data and address. A STOP placed directly after a data acknowledge raises a commit pulse, which tells that controller to start its write cycle.

A read selection streams bytes from a combinational memory read port, starting at the address counter. The counter moves on by one after each byte. The engine keeps silent while the write controller reports a busy cycle, and it refuses data bytes while writes are inhibited.

Top module: `i2cm_target`

## Requirements
- R1: A START is a falling SDA edge while SCL is high, and a STOP is a rising SDA edge while SCL is high. A START seen during any transfer, including a repeated START, restarts selection with a fresh device byte.
- R2: Received bits are taken on SCL rising edges, MSB first. `sda_oe_o` only becomes asserted while the synchronised SCL is low.
- R3: The device byte is type[7:4], chip-enable[3:1] and direction[0], where 1 means read. It is acknowledged only when type is 4'b1010 (main array, `aux_o`=0) or 4'b1011 (auxiliary page, `aux_o`=1) and bits [3:1] equal `chip_en_i[2:0]`.
- R4: After a device byte that is not acknowledged, the engine ignores all bus traffic and never drives SDA until the next START.
- R5: After a write selection, two address bytes are acknowledged, high byte first. Their lower ADDR_W bits load the address counter shown on `mem_addr_o`.
- R6: Each data byte received while `wr_inhibit_i` is low is acknowledged. It produces a one-cycle `wr_strobe_o` with `wr_data_o` and `wr_addr_o`, and the address counter then moves up by one.
- R7: While `wr_inhibit_i` is high, device and address bytes are still acknowledged, but data bytes get NoAck and produce no strobe.
- R8: `commit_o` pulses for one cycle, together with `stop_o`, only when a STOP follows the acknowledge slot of an accepted data byte. A STOP anywhere else gives no commit.
- R9: While `wr_busy_i` is high, SDA is released from the next cycle on, STARTs are ignored and nothing is acknowledged, so a master can poll with its device byte.
- R10: A read selection with no address phase (current-address read) sends bytes from `rd_data_i` at `mem_addr_o`, MSB first. The counter moves up by one after each byte.
- R11: In a read, a master ACK in the ninth slot continues with the next byte. A master NoAck ends the transfer, releases SDA and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| chip_en_i | input | 3 | Strap value compared with device byte bits [3:1] |
| wr_inhibit_i | input | 1 | High refuses data bytes of writes |
| wr_busy_i | input | 1 | Downstream write cycle in progress |
| rd_data_i | input | 8 | Memory read data for `mem_addr_o`/`aux_o`, combinational |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mem_addr_o | output | ADDR_W | Current address counter |
| aux_o | output | 1 | Selected space: 0 main array, 1 auxiliary page |
| wr_strobe_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_data_o | output | 8 | Data of the accepted byte |
| wr_addr_o | output | ADDR_W | Address of the accepted byte |
| commit_o | output | 1 | STOP came right after a data acknowledge |
| stop_o | output | 1 | Any STOP detected |

## Verification
The bench sends a device byte after a chip-enable mismatch with no new START. An engine that does not truly go idle would acknowledge that byte. A STOP is placed right after the address acknowledge, where a loose slot check would raise a false commit. A write is run with the inhibit input high, where a wrong engine would acknowledge or strobe the data, or would refuse the address bytes as well. A current-address read follows a three-byte write to confirm that the counter moved past the last written byte. An auxiliary-page random read with a repeated START tests type decoding and the master ACK/NoAck handling. Polling while busy must give NoAck, and a released busy must give an acknowledge.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA, ST_RDATA
  } state_e;

  localparam logic [3:0] TYPE_MAIN = 4'b1010;
  localparam logic [3:0] TYPE_AUX  = 4'b1011;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES:0][W-1:0] pipe_q;

  // Bus idles high, so reset to ones.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/i2cm_cond.sv
module i2cm_cond (
  input  logic scl_i,
  input  logic scl_prev_i,
  input  logic sda_i,
  input  logic sda_prev_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_held;
  assign scl_held   = scl_i & scl_prev_i;
  assign scl_rise_o = scl_i & ~scl_prev_i;
  assign scl_fall_o = ~scl_i & scl_prev_i;
  assign start_o    = scl_held & sda_prev_i & ~sda_i;
  assign stop_o     = scl_held & ~sda_prev_i & sda_i;
endmodule

// File: rtl/i2cm_target.sv
module i2cm_target
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_en_i,
  input  logic              wr_inhibit_i,
  input  logic              wr_busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              aux_o,
  output logic              wr_strobe_o,
  output logic [7:0]        wr_data_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              commit_o,
  output logic              stop_o
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({scl_i, sda_i}),
    .sync_o ({scl_s, sda_s}),
    .prev_o ({scl_p, sda_p})
  );

  i2cm_cond u_cond (
    .scl_i     (scl_s),
    .scl_prev_i(scl_p),
    .sda_i     (sda_s),
    .sda_prev_i(sda_p),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  state_e            state_q, nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q, oe_q, mack_q, wr_any_q, aux_q;
  logic [7:0]        sh_q;
  logic [6:0]        tx_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] addr_q, waddr_q;
  logic [7:0]        wdata_q;
  logic              strobe_q, commit_q, stop_q;
  logic              sel_ok;

  assign sel_ok = ((sh_q[7:4] == TYPE_MAIN) || (sh_q[7:4] == TYPE_AUX)) &&
                  (sh_q[3:1] == chip_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt_q    <= '0;
      in_ack_q <= 1'b0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b0;
      wr_any_q <= 1'b0;
      aux_q    <= 1'b0;
      sh_q     <= '0;
      tx_q     <= '0;
      hi_q     <= '0;
      addr_q   <= '0;
      waddr_q  <= '0;
      wdata_q  <= '0;
      strobe_q <= 1'b0;
      commit_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      commit_q <= 1'b0;
      stop_q   <= 1'b0;
      if (wr_busy_i) begin
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        in_ack_q <= 1'b0;
      end else if (start_det) begin
        state_q  <= ST_DEVSEL;
        cnt_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
        wr_any_q <= 1'b0;
      end else if (stop_det) begin
        stop_q   <= 1'b0 == 1'b0;
        // STOP in the slot right after a data ack: first bit sampled, no more.
        commit_q <= (state_q == ST_WDATA) && (cnt_q == CNT_W'(1)) &&
                    !in_ack_q && wr_any_q;
        state_q  <= ST_IDLE;
        oe_q     <= 1'b0;
        in_ack_q <= 1'b0;
      end else if (state_q == ST_RDATA) begin
        if (scl_rise) begin
          if (in_ack_q) mack_q <= ~sda_s;
          else          cnt_q  <= cnt_q + 1'b1;
        end else if (scl_fall) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            if (mack_q) begin
              tx_q  <= rd_data_i[6:0];
              oe_q  <= ~rd_data_i[7];
              cnt_q <= '0;
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end else if (cnt_q == LAST) begin
            in_ack_q <= 1'b1;
            oe_q     <= 1'b0;
            addr_q   <= addr_q + 1'b1;
          end else begin
            tx_q <= {tx_q[5:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end
      end else if (state_q != ST_IDLE) begin
        if (scl_rise && (cnt_q < LAST)) begin
          sh_q  <= {sh_q[6:0], sda_s};
          cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall && in_ack_q) begin
          in_ack_q <= 1'b0;
          cnt_q    <= '0;
          state_q  <= nxt_q;
          if (nxt_q == ST_RDATA) begin
            tx_q <= rd_data_i[6:0];
            oe_q <= ~rd_data_i[7];
          end else begin
            oe_q <= 1'b0;
          end
        end else if (scl_fall && (cnt_q == LAST)) begin
          unique case (state_q)
            ST_DEVSEL: begin
              if (sel_ok) begin
                in_ack_q <= 1'b1;
                oe_q     <= 1'b1;
                aux_q    <= sh_q[4];
                nxt_q    <= sh_q[0] ? ST_RDATA : ST_ADDR_HI;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_ADDR_HI: begin
              in_ack_q <= 1'b1;
              oe_q     <= 1'b1;
              hi_q     <= sh_q[HI_W-1:0];
              nxt_q    <= ST_ADDR_LO;
            end
            ST_ADDR_LO: begin
              in_ack_q <= 1'b1;
              oe_q     <= 1'b1;
              addr_q   <= {hi_q, sh_q};
              nxt_q    <= ST_WDATA;
            end
            ST_WDATA: begin
              in_ack_q <= 1'b1;
              nxt_q    <= ST_WDATA;
              if (!wr_inhibit_i) begin
                oe_q     <= 1'b1;
                strobe_q <= 1'b1;
                wdata_q  <= sh_q;
                waddr_q  <= addr_q;
                addr_q   <= addr_q + 1'b1;
                wr_any_q <= 1'b1;
              end
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = addr_q;
  assign aux_o       = aux_q;
  assign wr_strobe_o = strobe_q;
  assign wr_data_o   = wdata_q;
  assign wr_addr_o   = waddr_q;
  assign commit_o    = commit_q;
  assign stop_o      = stop_q;
endmodule

// File: rtl/i2cm_target_chk.sv
module i2cm_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic wr_busy_i,
  input logic wr_inhibit_i,
  input logic wr_strobe_o,
  input logic commit_o,
  input logic stop_o
);
  p_drive_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  p_busy_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy_i |=> !sda_oe_o);

  p_strobe_acked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> sda_oe_o);

  p_strobe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o);

  p_no_strobe_inhibit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> !$past(wr_inhibit_i));

  p_commit_on_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> stop_o);

  p_commit_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

bind i2cm_target i2cm_target_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_s       (scl_s),
  .sda_oe_o    (sda_oe_o),
  .wr_busy_i   (wr_busy_i),
  .wr_inhibit_i(wr_inhibit_i),
  .wr_strobe_o (wr_strobe_o),
  .commit_o    (commit_o),
  .stop_o      (stop_o)
);

// File: tb/i2cm_target_tb.sv
module i2cm_target_tb;
  localparam int ADDR_W = 15;
  localparam int QTR    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] chip_en = 3'b101;
  logic wr_inhibit = 1'b0, wr_busy = 1'b0;
  logic [7:0] rd_data;
  logic sda_oe, aux, wr_strobe, commit, stop_p;
  logic [ADDR_W-1:0] mem_addr, wr_addr;
  logic [7:0] wr_data;
  logic sda_bus;

  int checks = 0, fails = 0;
  int wr_n = 0, commit_n = 0, busy_drive = 0;
  logic [7:0] log_d [16];
  logic [ADDR_W-1:0] log_a [16];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] mem_model(input logic [ADDR_W-1:0] a, input logic x);
    return x ? (8'hC3 ^ a[7:0]) : (a[7:0] + {1'b0, a[14:8]});
  endfunction

  assign rd_data = mem_model(mem_addr, aux);

  i2cm_target #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_en_i(chip_en), .wr_inhibit_i(wr_inhibit), .wr_busy_i(wr_busy),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr),
    .aux_o(aux), .wr_strobe_o(wr_strobe), .wr_data_o(wr_data),
    .wr_addr_o(wr_addr), .commit_o(commit), .stop_o(stop_p)
  );

  always @(posedge clk) begin
    if (wr_strobe && wr_n < 16) begin
      log_d[wr_n] = wr_data;
      log_a[wr_n] = wr_addr;
      wr_n = wr_n + 1;
    end
    if (commit) commit_n = commit_n + 1;
    if (wr_busy && sda_oe) busy_drive = busy_drive + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    acked = !sda_bus;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      b[i] = sda_bus;
      q(); scl_m = 1'b0; q();
    end
    sda_m = give_ack ? 1'b0 : 1'b1; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R2 reset release", sda_oe, 0);
    check(wr_strobe == 1'b0 && commit == 1'b0, "R8 reset pulses", {wr_strobe, commit}, 0);
  endtask

  task automatic t_bad_select();
    bit a;
    bus_start();
    send_byte(8'hA6, a);  // ce field 011 vs straps 101
    check(!a, "R3 ce mismatch nack", a, 0);
    send_byte(8'hAA, a);  // matching byte without START
    check(!a, "R4 idle until start", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h9A, a);  // type 1001
    check(!a, "R3 bad type nack", a, 0);
    bus_stop();
  endtask

  task automatic t_write();
    bit a;
    int base = wr_n;
    int c0 = commit_n;
    bus_start();
    send_byte(8'hAA, a); check(a, "R3 main write select ack", a, 1);
    send_byte(8'h01, a); check(a, "R5 addr hi ack", a, 1);
    send_byte(8'h20, a); check(a, "R5 addr lo ack", a, 1);
    send_byte(8'h11, a); check(a, "R6 data ack", a, 1);
    send_byte(8'h22, a);
    send_byte(8'h93, a); check(a, "R6 data ack last", a, 1);
    bus_stop();
    q();
    check(wr_n - base == 3, "R6 strobe count", wr_n - base, 3);
    check(log_d[base] == 8'h11 && log_a[base] == 15'h0120, "R6 first byte", {log_a[base], log_d[base]}, 32'h12011);
    check(log_d[base+2] == 8'h93 && log_a[base+2] == 15'h0122, "R6 third byte", {log_a[base+2], log_d[base+2]}, 32'h12293);
    check(commit_n - c0 == 1, "R8 commit after data ack", commit_n - c0, 1);
    check(mem_addr == 15'h0123, "R6 counter advanced", mem_addr, 15'h0123);
  endtask

  task automatic t_current_read();
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hAB, a); check(a, "R3 read select ack", a, 1);
    recv_byte(1'b1, b);
    check(b == mem_model(15'h0123, 1'b0), "R10 current address byte", b, mem_model(15'h0123, 1'b0));
    recv_byte(1'b0, b);
    check(b == mem_model(15'h0124, 1'b0), "R11 byte after master ack", b, mem_model(15'h0124, 1'b0));
    q();
    check(sda_oe == 1'b0, "R11 released after noack", sda_oe, 0);
    send_byte(8'hAB, a);  // no START: engine must stay idle
    check(!a, "R11 idle after noack", a, 0);
    bus_stop();
  endtask

  task automatic t_aux_random_read();
    bit a;
    logic [7:0] b;
    int c0 = commit_n;
    bus_start();
    send_byte(8'hBA, a); check(a, "R3 aux write select ack", a, 1);
    send_byte(8'h00, a);
    send_byte(8'h05, a);
    bus_start();  // repeated START
    send_byte(8'hBB, a); check(a, "R1 repeated start select", a, 1);
    check(aux == 1'b1, "R3 aux flag", aux, 1);
    recv_byte(1'b1, b);
    check(b == mem_model(15'h0005, 1'b1), "R10 aux byte 0", b, mem_model(15'h0005, 1'b1));
    recv_byte(1'b0, b);
    check(b == mem_model(15'h0006, 1'b1), "R11 aux byte 1", b, mem_model(15'h0006, 1'b1));
    bus_stop();
    q();
    check(commit_n == c0, "R8 no commit on read", commit_n - c0, 0);
  endtask

  task automatic t_inhibit();
    bit a;
    int base = wr_n;
    int c0 = commit_n;
    wr_inhibit = 1'b1;
    bus_start();
    send_byte(8'hAA, a); check(a, "R7 select ack inhibited", a, 1);
    send_byte(8'h02, a); check(a, "R7 addr ack inhibited", a, 1);
    send_byte(8'h00, a);
    send_byte(8'h55, a); check(!a, "R7 data nack", a, 0);
    send_byte(8'h66, a); check(!a, "R7 second data nack", a, 0);
    bus_stop();
    q();
    check(wr_n == base, "R7 no strobe", wr_n - base, 0);
    check(commit_n == c0, "R8 no commit inhibited", commit_n - c0, 0);
    wr_inhibit = 1'b0;
  endtask

  task automatic t_no_commit();
    bit a;
    int c0 = commit_n;
    bus_start();
    send_byte(8'hAA, a);
    send_byte(8'h00, a);
    send_byte(8'h10, a);
    bus_stop();
    q();
    check(commit_n == c0, "R8 stop after address", commit_n - c0, 0);
    check(mem_addr == 15'h0010, "R5 address loaded", mem_addr, 15'h0010);
  endtask

  task automatic t_busy();
    bit a;
    wr_busy = 1'b1;
    q();
    bus_start();
    send_byte(8'hAA, a); check(!a, "R9 poll nack while busy", a, 0);
    bus_stop();
    check(busy_drive == 0, "R9 no drive while busy", busy_drive, 0);
    wr_busy = 1'b0;
    q();
    bus_start();
    send_byte(8'hAA, a); check(a, "R9 poll ack when ready", a, 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    q();
    t_reset();
    t_bad_select();
    t_write();
    t_current_read();
    t_aux_random_read();
    t_inhibit();
    t_no_commit();
    t_busy();
    q();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule